// File: doc/BRIEF.md
# Ten-bit I2C Target Address Matcher

This block decides whether an I2C target with a ten-bit address is being spoken to. A bit-level receiver next to it turns the bus into single-cycle events: a plain START, a repeated START, a STOP, and each completed eight-bit byte. From these events the matcher works out whether the byte just received must be acknowledged, and reports whether the target now accepts data (write) or drives data (read). The bit-level shifter and the handling of data bytes are outside this block.

A ten-bit address takes two bytes. The first, the header, starts with the fixed pattern `11110`, carries address bits 9 and 8 in bits 2:1, and carries the direction in bit 0 (0 = write, 1 = read). The second byte carries address bits 7:0. Every target whose upper two bits match acknowledges the header. Only the target whose whole address matches acknowledges the second byte, and that target then remembers that it has been selected. A read is done as a full two-byte write addressing, then a repeated START and the header alone with the direction bit set. Only the target that remembers being selected acknowledges that short read header.

The own address is a static input that is compared directly, with no pipeline stage. `ack_req` is a one-cycle pulse in the clock after the receiver presents the byte. `match_wr` and `match_rd` change in that same cycle and hold until the next START, repeated START or STOP.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, `ack_req`, `match_wr` and `match_rd` are 0 and the target is not selected, so a read header after a repeated START gets no acknowledge.
- R2: After a START or repeated START, a first byte equal to `11110`, then `own_addr[9:8]` in bits 2:1, then 0 in bit 0, makes `ack_req` 1 for exactly the one cycle after the byte's `rx_valid` cycle.
- R3: A first byte whose bits 7:3 are not `11110`, or whose bits 2:1 differ from `own_addr[9:8]`, gets no acknowledge. Every byte after it gets no acknowledge and sets no match flag until the next START or repeated START.
- R4: After an acknowledged write header, a second byte equal to `own_addr[7:0]` is acknowledged and sets `match_wr` in the same cycle as the acknowledge. Later data bytes, even ones that look like headers, get no acknowledge and leave `match_wr` at 1.
- R5: A second byte that differs from `own_addr[7:0]` gets no acknowledge and leaves `match_wr` at 0. It also clears the selected state, so a read header after a repeated START then gets no acknowledge.
- R6: When the target is selected, a repeated START followed by the header with bit 0 = 1 is acknowledged and sets `match_rd`. `match_wr` stays 0, and `match_wr` and `match_rd` are never both 1.
- R7: A read header (bit 0 = 1) that follows a plain START gets no acknowledge, even when the target is selected, and it clears the selected state.
- R8: A read header after a repeated START gets no acknowledge when the target is not selected.
- R9: A STOP clears `match_wr`, `match_rd` and the selected state from the next cycle on.
- R10: A START or repeated START followed by a first byte that is not the matching header (with either direction) clears the selected state.
- R11: A START or repeated START sets `match_wr` and `match_rd` to 0 from the next cycle on. When several events arrive in one cycle, STOP wins, then START, then repeated START, then the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_addr | input | ADDR_W (10) | Static ten-bit address of this target |
| evt_start | input | 1 | One-cycle pulse: plain START seen on the bus |
| evt_rstart | input | 1 | One-cycle pulse: repeated START seen on the bus |
| evt_stop | input | 1 | One-cycle pulse: STOP seen on the bus |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| ack_req | output | 1 | Pulse asking the receiver to pull SDA low in the ninth clock |
| match_wr | output | 1 | Fully addressed for a write; the target receives data |
| match_rd | output | 1 | Addressed for a read; the target transmits data |

## Verification
The bench builds the block with the default `ADDR_W` of 10, and it changes the static `own_addr` between two runs: first 0x2B5, then 0x3FF. The first value makes the upper bits differ from the header's other codes, so a header can match in prefix but miss in bits 9:8. The all-ones value drives the header comparison and the low-byte comparison at their top codes. Both runs go through the full read sequence: write addressing, repeated START, then the short read header. This covers every way the remembered selection can be cleared: a STOP, a wrong low byte, a foreign first byte, and a read header after a plain START.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int BYTE_W = 8;

    // Position in the addressing sequence
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_LOW,
        ST_DATA,
        ST_SKIP
    } phase_e;

    // One bus event per cycle after arbitration
    typedef enum logic [2:0] {
        EV_NONE,
        EV_STOP,
        EV_START,
        EV_RSTART,
        EV_BYTE
    } ev_e;

    // Result of comparing a received byte with the own address
    typedef struct packed {
        logic hdr_form;
        logic hi_hit;
        logic rd;
        logic lo_hit;
    } hit_t;

    // Fixed header prefix: all ones, then a single zero
    function automatic logic [BYTE_W-1:0] hdr_prefix(input int pfx_w);
        logic [BYTE_W-1:0] v;
        v = '0;
        for (int i = 1; i < pfx_w; i++) v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/i2c10_evt_arb.sv
module i2c10_evt_arb
    import i2c10_pkg::*;
(
    input  logic evt_start,
    input  logic evt_rstart,
    input  logic evt_stop,
    input  logic rx_valid,
    output ev_e  ev
);

    always_comb begin
        if (evt_stop)        ev = EV_STOP;
        else if (evt_start)  ev = EV_START;
        else if (evt_rstart) ev = EV_RSTART;
        else if (rx_valid)   ev = EV_BYTE;
        else                 ev = EV_NONE;
    end

endmodule

// File: rtl/i2c10_hdr_decode.sv
module i2c10_hdr_decode
    import i2c10_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output hit_t              hit
);

    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int PFX_W = BYTE_W - 1 - HI_W;
    localparam logic [BYTE_W-1:0] PFX_FULL = hdr_prefix(PFX_W);
    localparam logic [PFX_W-1:0]  PFX      = PFX_FULL[PFX_W-1:0];

    logic [HI_W-1:0]   hi_eq;
    logic [BYTE_W-1:0] lo_eq;

    // Bitwise compare of the upper address bits carried in the header
    for (genvar gi = 0; gi < HI_W; gi++) begin : g_hi
        assign hi_eq[gi] = (rx_byte[gi+1] == own_addr[BYTE_W+gi]);
    end

    // Bitwise compare of the low address byte
    for (genvar gj = 0; gj < BYTE_W; gj++) begin : g_lo
        assign lo_eq[gj] = (rx_byte[gj] == own_addr[gj]);
    end

    always_comb begin
        hit.hdr_form = (rx_byte[BYTE_W-1:HI_W+1] == PFX);
        hit.hi_hit   = &hi_eq;
        hit.rd       = rx_byte[0];
        hit.lo_hit   = &lo_eq;
    end

endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
    import i2c10_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ev_e  ev,
    input  hit_t hit,
    output logic ack_req,
    output logic match_wr,
    output logic match_rd
);

    phase_e ph_q;
    logic   sel_q;   // fully addressed last
    logic   rs_q;    // current header follows a repeated START
    logic   hdr_hit;

    assign hdr_hit = hit.hdr_form && hit.hi_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= ST_IDLE;
            sel_q    <= 1'b0;
            rs_q     <= 1'b0;
            ack_req  <= 1'b0;
            match_wr <= 1'b0;
            match_rd <= 1'b0;
        end else begin
            ack_req <= 1'b0;
            case (ev)
                EV_STOP: begin
                    ph_q     <= ST_IDLE;
                    sel_q    <= 1'b0;
                    match_wr <= 1'b0;
                    match_rd <= 1'b0;
                end
                EV_START, EV_RSTART: begin
                    ph_q     <= ST_HDR;
                    rs_q     <= (ev == EV_RSTART);
                    match_wr <= 1'b0;
                    match_rd <= 1'b0;
                end
                EV_BYTE: begin
                    case (ph_q)
                        ST_HDR: begin
                            if (hdr_hit && !hit.rd) begin
                                ack_req <= 1'b1;
                                ph_q    <= ST_LOW;
                            end else if (hdr_hit && rs_q && sel_q) begin
                                ack_req  <= 1'b1;
                                match_rd <= 1'b1;
                                ph_q     <= ST_DATA;
                            end else begin
                                sel_q <= 1'b0;
                                ph_q  <= ST_SKIP;
                            end
                        end
                        ST_LOW: begin
                            if (hit.lo_hit) begin
                                ack_req  <= 1'b1;
                                sel_q    <= 1'b1;
                                match_wr <= 1'b1;
                                ph_q     <= ST_DATA;
                            end else begin
                                sel_q <= 1'b0;
                                ph_q  <= ST_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
    import i2c10_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              evt_start,
    input  logic              evt_rstart,
    input  logic              evt_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              ack_req,
    output logic              match_wr,
    output logic              match_rd
);

    ev_e  ev;
    hit_t hit;

    i2c10_evt_arb u_arb (
        .evt_start (evt_start),
        .evt_rstart(evt_rstart),
        .evt_stop  (evt_stop),
        .rx_valid  (rx_valid),
        .ev        (ev)
    );

    i2c10_hdr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rx_byte (rx_byte),
        .own_addr(own_addr),
        .hit     (hit)
    );

    i2c10_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .hit     (hit),
        .ack_req (ack_req),
        .match_wr(match_wr),
        .match_rd(match_rd)
    );

endmodule

// File: rtl/i2c10_addr_match_chk.sv
module i2c10_addr_match_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] own_addr,
    input logic              evt_start,
    input logic              evt_rstart,
    input logic              evt_stop,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              ack_req,
    input logic              match_wr,
    input logic              match_rd
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(match_wr && match_rd));                                            // R6

    AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> $past(rx_valid));                                        // R2

    AST_STOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> (!match_wr && !match_rd && !ack_req));                  // R9

    AST_START_DROPS: assert property (@(posedge clk) disable iff (rst)
        (evt_start || evt_rstart) |=> (!match_wr && !match_rd));             // R11

    AST_WR_RISE_ACKED: assert property (@(posedge clk) disable iff (rst)
        $rose(match_wr) |-> (ack_req && $past(rx_byte) == $past(own_addr[7:0]))); // R4

    AST_RD_RISE_ACKED: assert property (@(posedge clk) disable iff (rst)
        $rose(match_rd) |-> (ack_req && $past(rx_byte[0])));                 // R6

endmodule

bind i2c10_addr_match i2c10_addr_match_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .own_addr  (own_addr),
    .evt_start (evt_start),
    .evt_rstart(evt_rstart),
    .evt_stop  (evt_stop),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .ack_req   (ack_req),
    .match_wr  (match_wr),
    .match_rd  (match_rd)
);

// File: tb/test_i2c10_addr_match.sv
module test_i2c10_addr_match;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] own_addr = 10'h2B5;
    logic       evt_start = 1'b0, evt_rstart = 1'b0, evt_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_req, match_wr, match_rd;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    i2c10_addr_match i_i2c10_addr_match (
        .clk(clk), .rst(rst), .own_addr(own_addr),
        .evt_start(evt_start), .evt_rstart(evt_rstart), .evt_stop(evt_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_req(ack_req), .match_wr(match_wr), .match_rd(match_rd)
    );

    // Behavioural reference: 0 idle, 1 want first byte, 2 want low byte, 3 data, 4 ignore
    int m_phase = 0;
    bit m_chosen = 0, m_after_rs = 0;
    bit e_ack = 0, e_wr = 0, e_rd = 0;

    always @(posedge clk) begin
        bit head_ok;
        if (rst) begin
            m_phase = 0; m_chosen = 0; m_after_rs = 0;
            e_ack = 0; e_wr = 0; e_rd = 0;
        end else begin
            e_ack = 0;
            head_ok = (int'(rx_byte) >> 1) == (8'h78 + int'(own_addr) / 256);
            if (evt_stop) begin
                m_phase = 0; m_chosen = 0; e_wr = 0; e_rd = 0;
            end else if (evt_start || evt_rstart) begin
                m_phase = 1; m_after_rs = !evt_start; e_wr = 0; e_rd = 0;
            end else if (rx_valid) begin
                if (m_phase == 1) begin
                    if (head_ok && rx_byte[0] == 0) begin
                        e_ack = 1; m_phase = 2;
                    end else if (head_ok && m_after_rs && m_chosen) begin
                        e_ack = 1; e_rd = 1; m_phase = 3;
                    end else begin
                        m_chosen = 0; m_phase = 4;
                    end
                end else if (m_phase == 2) begin
                    if (int'(rx_byte) == int'(own_addr) % 256) begin
                        e_ack = 1; e_wr = 1; m_chosen = 1; m_phase = 3;
                    end else begin
                        m_chosen = 0; m_phase = 4;
                    end
                end
            end
        end
    end

    // Cycle compare against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if ({ack_req, match_wr, match_rd} !== {e_ack, e_wr, e_rd}) begin
                n_errors++;
                $display("FAIL cycle-compare (R2/R4/R6) at %0t: got ack/wr/rd=%b%b%b expected %b%b%b",
                         $time, ack_req, match_wr, match_rd, e_ack, e_wr, e_rd);
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // kind: 0 start, 1 repeated start, 2 stop
    task automatic evt(input int kind);
        @(negedge clk);
        evt_start  = (kind == 0);
        evt_rstart = (kind == 1);
        evt_stop   = (kind == 2);
        @(negedge clk);
        evt_start = 0; evt_rstart = 0; evt_stop = 0;
    endtask

    task automatic send(input logic [7:0] b, output logic a);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        @(negedge clk);
        rx_valid = 0;
        a = ack_req;
    endtask

    logic a;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ack_req, 0, "R1 ack after reset");
        chk(match_wr | match_rd, 0, "R1 flags after reset");
        evt(1); send(8'hF5, a); chk(a, 0, "R1/R8 read header unselected");

        // Write addressing, data, stop
        evt(0); send(8'hF4, a); chk(a, 1, "R2 write header ack");
        @(negedge clk); chk(ack_req, 0, "R2 ack lasts one cycle");
        send(8'hB5, a); chk(a, 1, "R4 low byte ack"); chk(match_wr, 1, "R4 match_wr set");
        send(8'hF4, a); chk(a, 0, "R4 data byte not acked"); chk(match_wr, 1, "R4 match_wr held");
        evt(2); chk(match_wr, 0, "R9 stop clears match_wr");

        // Mismatching first bytes
        evt(0); send(8'hF0, a); chk(a, 0, "R3 wrong upper bits");
        send(8'hB5, a); chk(a, 0, "R3 later byte ignored"); chk(match_wr, 0, "R3 no match");
        evt(0); send(8'hA0, a); chk(a, 0, "R3 seven-bit style byte");

        // Wrong low byte
        evt(0); send(8'hF4, a); send(8'hB4, a); chk(a, 0, "R5 wrong low byte");
        chk(match_wr, 0, "R5 match_wr low");
        evt(1); send(8'hF5, a); chk(a, 0, "R5 selection cleared");

        // Full read sequence
        evt(0); send(8'hF4, a); send(8'hB5, a);
        evt(1); chk(match_wr, 0, "R11 repeated start drops match_wr");
        send(8'hF5, a); chk(a, 1, "R6 read header acked");
        chk(match_rd, 1, "R6 match_rd set"); chk(match_wr, 0, "R6 match_wr low");
        send(8'h00, a); chk(a, 0, "R6 data byte not acked");

        // Read header after plain START
        evt(0); chk(match_rd, 0, "R11 start drops match_rd");
        send(8'hF5, a); chk(a, 0, "R7 read after plain start");
        evt(1); send(8'hF5, a); chk(a, 0, "R7 selection cleared");

        // STOP clears selection
        evt(0); send(8'hF4, a); send(8'hB5, a); evt(2);
        evt(1); send(8'hF5, a); chk(a, 0, "R9 stop clears selection");

        // Foreign first byte clears selection
        evt(0); send(8'hF4, a); send(8'hB5, a);
        evt(1); send(8'h90, a); chk(a, 0, "R10 foreign byte nacked");
        evt(1); send(8'hF5, a); chk(a, 0, "R10 selection cleared");
        evt(0); send(8'hF4, a); send(8'hB5, a);
        evt(1); send(8'hF1, a); chk(a, 0, "R10 read header other upper bits");
        evt(1); send(8'hF5, a); chk(a, 0, "R10 selection cleared by other header");

        // Priority: STOP and byte together
        evt(0); send(8'hF4, a);
        @(negedge clk); evt_stop = 1; rx_valid = 1; rx_byte = 8'hB5;
        @(negedge clk); evt_stop = 0; rx_valid = 0;
        chk(ack_req, 0, "R11 stop beats byte"); chk(match_wr, 0, "R11 stop beats byte flag");

        // Second own address at top codes
        evt(2);
        own_addr = 10'h3FF;
        evt(0); send(8'hF6, a); chk(a, 1, "R2 header with all-ones upper bits");
        send(8'hFF, a); chk(a, 1, "R4 low byte all ones");
        evt(1); send(8'hF7, a); chk(a, 1, "R6 read with second address");
        chk(match_rd, 1, "R6 match_rd second address");
        evt(2);
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule